// File: doc/BRIEF.md
# Dual-Half General Purpose Timer

This block is a register-mapped timer built from two 16-bit halves, A and B. A configuration code decides how the halves are used. Code 0 joins the two load halves into one 32-bit interval and counts it down in units of `CLK_SCALE` clock cycles. Code 1 turns the block into a seconds counter that advances once every `SEC_CYCLES` cycles. In that mode the count is compared with the two match halves, joined the same way.

Software sets up the timer through a word-indexed register port and starts it with an enable bit. A countdown timeout sets a status bit. The timer then either reloads and runs again, or stops itself when the one-shot mode bit is set. When the trigger-enable bit is set, each countdown timeout also drives a one-cycle pulse on a trigger line for an ADC. A single level interrupt is raised whenever a raw status bit is set and its mask bit is also set.

Register index map on `bus_addr`: 0 configuration, 1 mode A, 2 mode B, 3 control, 4 interrupt mask, 5 raw status, 6 masked status, 7 status clear, 8 load A, 9 load B, 10 match A, 11 match B, 12 prescale A, 13 prescale B, 14 prescale-match A, 15 prescale-match B.

Top module: `dual_half_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `adc_trig` are low.
- R2: Interrupt-mask writes keep only bits 6:4 and 2:0 (0x77). The four prescale and prescale-match registers read back the low `PRE_W` bits written. The control register stores only bit 0 (enable), bit 5 (trigger enable) and bit 8 (half-B enable).
- R3: A write to load A or match A puts bits 15:0 in half A and bits 31:16 in half B. A write to load B or match B puts bits 15:0 in half B. Load A and match A read back both halves while the configuration is below 4, and only half A otherwise.
- R4: With configuration 0, a 0-to-1 write of control bit 0 loads the 32-bit interval L. Raw status bit 0 sets max(L,1)*`CLK_SCALE` cycles after the enabling edge. Without one-shot, the timer reloads and times out again with that same period.
- R5: When mode-A bit 0 is set, a timeout clears control bit 0, and no further timeouts follow.
- R6: With configuration 0 and control bit 5 set, `adc_trig` is high for exactly the one cycle after each timeout. With bit 5 clear it stays low.
- R7: With configuration 1, enabling clears the seconds count, which then rises by 1 every `SEC_CYCLES` cycles. Raw status bit 3 sets on the cycle the count reaches the 32-bit match value. No timeout and no trigger occur in this mode.
- R8: Masked status reads raw AND mask, and `irq` is high exactly when that result is nonzero.
- R9: A write to the clear register clears the raw status bits written as 1 and leaves the others.
- R10: Configuration and mode writes are ignored while control bit 0 is set.
- R11: Clearing control bit 0 stops the countdown. A later enable restarts it from the full interval.
- R12: Configuration codes other than 0 and 1 produce no status bits and no trigger pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| adc_trig | output | 1 | One-cycle ADC trigger pulse |

## Verification
Several properties are checked on every cycle:
- The mask register never holds a bit outside 0x77.
- Configuration and mode stay frozen while the timer is enabled.
- A timeout sets raw bit 0 and reloads the counter.
- A one-shot timeout drops the enable bit, and the trigger follows a timeout by exactly one cycle.
- The tick phase counter stays inside its period and clears when idle.

Only the bench's scenarios can show the actual periods in cycles for each interval, the exact cycle of an RTC match, the read-back splitting of the halves, and that unused configuration codes stay silent over long windows.

// File: rtl/dht_pkg.sv
`timescale 1ns/1ps
package dht_pkg;
  typedef enum logic [3:0] {
    RG_CFG      = 4'd0,
    RG_MODE_A   = 4'd1,
    RG_MODE_B   = 4'd2,
    RG_CTRL     = 4'd3,
    RG_IMASK    = 4'd4,
    RG_RAW      = 4'd5,
    RG_MASKED   = 4'd6,
    RG_CLEAR    = 4'd7,
    RG_LOAD_A   = 4'd8,
    RG_LOAD_B   = 4'd9,
    RG_MATCH_A  = 4'd10,
    RG_MATCH_B  = 4'd11,
    RG_PRE_A    = 4'd12,
    RG_PRE_B    = 4'd13,
    RG_PMATCH_A = 4'd14,
    RG_PMATCH_B = 4'd15
  } reg_sel_e;

  localparam logic [2:0] CFG_CHAIN     = 3'd0;
  localparam logic [2:0] CFG_RTC       = 3'd1;
  localparam logic [2:0] CFG_SPLIT_MIN = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TRIG_BIT = 5;
  localparam int CTRL_B_EN_BIT = 8;

  localparam int ST_W       = 7;
  localparam int ST_TIMEOUT = 0;
  localparam int ST_RTC     = 3;
  localparam logic [ST_W-1:0] IMASK_KEEP = 7'h77;
endpackage

// File: rtl/dht_tick_gen.sv
`timescale 1ns/1ps
module dht_tick_gen #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q, phase_d;

  assign tick = run && (phase_q == LAST);

  always_comb begin
    phase_d = phase_q;
    if (!run || tick) phase_d = '0;
    else              phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
  assert_idle_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase_q == '0);
endmodule

// File: rtl/dht_engine.sv
`timescale 1ns/1ps
module dht_engine
  import dht_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg,
  input  logic          enabled,
  input  logic          start,
  input  logic          unit_tick,
  input  logic          sec_tick,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] match_val,
  output logic          timeout,
  output logic          rtc_hit
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rtc_q, rtc_d;
  logic          cd_step, rtc_step;
  logic [CW-1:0] rtc_inc;

  assign cd_step  = enabled && (cfg == CFG_CHAIN) && unit_tick;
  assign rtc_step = enabled && (cfg == CFG_RTC) && sec_tick;
  assign rtc_inc  = rtc_q + 1'b1;
  assign timeout  = cd_step && (cnt_q <= CW'(1));
  assign rtc_hit  = rtc_step && (rtc_inc == match_val);

  always_comb begin
    cnt_d = cnt_q;
    rtc_d = rtc_q;
    if (start) begin
      cnt_d = load_val;
      rtc_d = '0;
    end else begin
      if (cd_step)  cnt_d = timeout ? load_val : cnt_q - 1'b1;
      if (rtc_step) rtc_d = rtc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rtc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rtc_q <= rtc_d;
    end
  end

  assert_timeout_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !start) |=> cnt_q == $past(load_val));
  assert_timeout_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cfg == CFG_CHAIN) && enabled);
  assert_rtc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_step && !start) |=> rtc_q == $past(rtc_q) + 1'b1);
endmodule

// File: rtl/dual_half_timer.sv
`timescale 1ns/1ps
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int PRE_W      = 8,
  parameter int CLK_SCALE  = 5,
  parameter int SEC_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [2*HALF_W-1:0] bus_wdata,
  output logic [2*HALF_W-1:0] bus_rdata,
  output logic                irq,
  output logic                adc_trig
);
  localparam int DW = 2 * HALF_W;

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  logic [2:0]        cfg_q, cfg_d;
  logic [3:0]        mode_a_q, mode_a_d, mode_b_q, mode_b_d;
  logic              en_q, en_d, trg_en_q, trg_en_d, ben_q, ben_d;
  logic [ST_W-1:0]   imask_q, imask_d, raw_q, raw_d;
  logic [HALF_W-1:0] load_lo_q, load_lo_d, load_hi_q, load_hi_d;
  logic [HALF_W-1:0] match_lo_q, match_lo_d, match_hi_q, match_hi_d;
  logic [PRE_W-1:0]  pre_a_q, pre_a_d, pre_b_q, pre_b_d;
  logic [PRE_W-1:0]  pm_a_q, pm_a_d, pm_b_q, pm_b_d;
  logic              trig_q, trig_d;

  logic ctrl_wr, start, unit_tick, sec_tick, timeout, rtc_hit;

  assign ctrl_wr = bus_wr && (sel == RG_CTRL);
  assign start   = ctrl_wr && bus_wdata[CTRL_EN_BIT] && !en_q;

  dht_tick_gen #(.DIV(CLK_SCALE)) u_unit_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q && (cfg_q == CFG_CHAIN)),
    .tick (unit_tick)
  );

  dht_tick_gen #(.DIV(SEC_CYCLES)) u_sec_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q && (cfg_q == CFG_RTC)),
    .tick (sec_tick)
  );

  dht_engine #(.CW(DW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .enabled  (en_q),
    .start    (start),
    .unit_tick(unit_tick),
    .sec_tick (sec_tick),
    .load_val ({load_hi_q, load_lo_q}),
    .match_val({match_hi_q, match_lo_q}),
    .timeout  (timeout),
    .rtc_hit  (rtc_hit)
  );

  always_comb begin
    cfg_d      = cfg_q;
    mode_a_d   = mode_a_q;
    mode_b_d   = mode_b_q;
    en_d       = en_q;
    trg_en_d   = trg_en_q;
    ben_d      = ben_q;
    imask_d    = imask_q;
    raw_d      = raw_q;
    load_lo_d  = load_lo_q;
    load_hi_d  = load_hi_q;
    match_lo_d = match_lo_q;
    match_hi_d = match_hi_q;
    pre_a_d    = pre_a_q;
    pre_b_d    = pre_b_q;
    pm_a_d     = pm_a_q;
    pm_b_d     = pm_b_q;

    if (bus_wr) begin
      unique case (sel)
        RG_CFG:      if (!en_q) cfg_d = bus_wdata[2:0];
        RG_MODE_A:   if (!en_q) mode_a_d = bus_wdata[3:0];
        RG_MODE_B:   if (!en_q) mode_b_d = bus_wdata[3:0];
        RG_CTRL: begin
          en_d     = bus_wdata[CTRL_EN_BIT];
          trg_en_d = bus_wdata[CTRL_TRIG_BIT];
          ben_d    = bus_wdata[CTRL_B_EN_BIT];
        end
        RG_IMASK:    imask_d = bus_wdata[ST_W-1:0] & IMASK_KEEP;
        RG_CLEAR:    raw_d = raw_q & ~bus_wdata[ST_W-1:0];
        RG_LOAD_A: begin
          load_lo_d = bus_wdata[HALF_W-1:0];
          load_hi_d = bus_wdata[DW-1:HALF_W];
        end
        RG_LOAD_B:   load_hi_d = bus_wdata[HALF_W-1:0];
        RG_MATCH_A: begin
          match_lo_d = bus_wdata[HALF_W-1:0];
          match_hi_d = bus_wdata[DW-1:HALF_W];
        end
        RG_MATCH_B:  match_hi_d = bus_wdata[HALF_W-1:0];
        RG_PRE_A:    pre_a_d = bus_wdata[PRE_W-1:0];
        RG_PRE_B:    pre_b_d = bus_wdata[PRE_W-1:0];
        RG_PMATCH_A: pm_a_d = bus_wdata[PRE_W-1:0];
        RG_PMATCH_B: pm_b_d = bus_wdata[PRE_W-1:0];
        default: ;
      endcase
    end

    if (timeout && mode_a_q[0] && !ctrl_wr) en_d = 1'b0;
    if (timeout) raw_d[ST_TIMEOUT] = 1'b1;
    if (rtc_hit) raw_d[ST_RTC] = 1'b1;
    trig_d = timeout && trg_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      mode_a_q   <= '0;
      mode_b_q   <= '0;
      en_q       <= 1'b0;
      trg_en_q   <= 1'b0;
      ben_q      <= 1'b0;
      imask_q    <= '0;
      raw_q      <= '0;
      load_lo_q  <= '0;
      load_hi_q  <= '0;
      match_lo_q <= '0;
      match_hi_q <= '0;
      pre_a_q    <= '0;
      pre_b_q    <= '0;
      pm_a_q     <= '0;
      pm_b_q     <= '0;
      trig_q     <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      mode_a_q   <= mode_a_d;
      mode_b_q   <= mode_b_d;
      en_q       <= en_d;
      trg_en_q   <= trg_en_d;
      ben_q      <= ben_d;
      imask_q    <= imask_d;
      raw_q      <= raw_d;
      load_lo_q  <= load_lo_d;
      load_hi_q  <= load_hi_d;
      match_lo_q <= match_lo_d;
      match_hi_q <= match_hi_d;
      pre_a_q    <= pre_a_d;
      pre_b_q    <= pre_b_d;
      pm_a_q     <= pm_a_d;
      pm_b_q     <= pm_b_d;
      trig_q     <= trig_d;
    end
  end

  logic wide_rd;
  assign wide_rd = cfg_q < CFG_SPLIT_MIN;

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RG_CFG:      bus_rdata = DW'(cfg_q);
      RG_MODE_A:   bus_rdata = DW'(mode_a_q);
      RG_MODE_B:   bus_rdata = DW'(mode_b_q);
      RG_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = en_q;
        bus_rdata[CTRL_TRIG_BIT] = trg_en_q;
        bus_rdata[CTRL_B_EN_BIT] = ben_q;
      end
      RG_IMASK:    bus_rdata = DW'(imask_q);
      RG_RAW:      bus_rdata = DW'(raw_q);
      RG_MASKED:   bus_rdata = DW'(raw_q & imask_q);
      RG_LOAD_A:   bus_rdata = wide_rd ? {load_hi_q, load_lo_q} : DW'(load_lo_q);
      RG_LOAD_B:   bus_rdata = DW'(load_hi_q);
      RG_MATCH_A:  bus_rdata = wide_rd ? {match_hi_q, match_lo_q} : DW'(match_lo_q);
      RG_MATCH_B:  bus_rdata = DW'(match_hi_q);
      RG_PRE_A:    bus_rdata = DW'(pre_a_q);
      RG_PRE_B:    bus_rdata = DW'(pre_b_q);
      RG_PMATCH_A: bus_rdata = DW'(pm_a_q);
      RG_PMATCH_B: bus_rdata = DW'(pm_b_q);
      default:     bus_rdata = '0;
    endcase
  end

  assign irq      = |(raw_q & imask_q);
  assign adc_trig = trig_q;

  assert_mask_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_q & ~IMASK_KEEP) == '0);
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(cfg_q) && $stable(mode_a_q) && $stable(mode_b_q));
  assert_timeout_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> raw_q[ST_TIMEOUT]);
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && mode_a_q[0] && !ctrl_wr) |=> !en_q);
  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && trg_en_q) |=> adc_trig);
  assert_trig_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !timeout |=> !adc_trig);
endmodule

// File: tb/dual_half_timer_test.sv
`timescale 1ns/1ps
module dual_half_timer_test;
  localparam int S   = 3;
  localparam int SEC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        adc_trig;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  dual_half_timer #(.HALF_W(16), .PRE_W(8), .CLK_SCALE(S), .SEC_CYCLES(SEC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .adc_trig(adc_trig)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1 reg", v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 trig", {31'b0, adc_trig}, 32'h0);

    // R2: mask, prescale, control storage
    wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R2 mask keep", v, 32'h77);
    wr(4, 32'h0);
    for (int a = 12; a < 16; a++) begin
      wr(4'(a), 32'h100 + 32'(a * 17)); rd(4'(a), v);
      chk("R2 prescale readback", v, 32'((a * 17) & 8'hFF));
    end
    wr(3, 32'h0000_FFFF); rd(3, v); chk("R2 ctrl bits", v, 32'h121);
    wr(3, 32'h0); wr(7, 32'h7F);

    // R3: half splitting and read width
    wr(8, 32'h1234_5678); rd(8, v); chk("R3 loadA full", v, 32'h1234_5678);
    rd(9, v); chk("R3 loadB high", v, 32'h1234);
    wr(9, 32'h0000_BEEF); rd(8, v); chk("R3 loadB into hi", v, 32'hBEEF_5678);
    wr(10, 32'hCAFE_0042); rd(10, v); chk("R3 matchA full", v, 32'hCAFE_0042);
    wr(11, 32'h0000_0101); rd(10, v); chk("R3 matchB into hi", v, 32'h0101_0042);
    for (int c = 4; c < 8; c++) begin
      wr(0, 32'(c));
      rd(8, v);  chk("R3 loadA narrow", v, 32'h5678);
      rd(10, v); chk("R3 matchA narrow", v, 32'h0042);
    end
    wr(0, 32'h3); rd(8, v); chk("R3 loadA wide cfg3", v, 32'hBEEF_5678);
    wr(0, 32'h0); wr(11, 32'h0);

    // R4 / R6: periodic sweep with trigger
    for (int l = 0; l < 6; l++) begin
      int per;
      per = ((l == 0) ? 1 : l) * S;
      wr(8, 32'(l));
      wr(3, 32'h21);
      for (int k = 1; k <= 3 * per; k++) begin
        @(negedge clk);
        rd(5, v);
        chk("R4 timeout status", {31'b0, v[0]}, {31'b0, k >= per});
        chk("R6 trigger pulse", {31'b0, adc_trig}, {31'b0, (k % per) == 0});
      end
      wr(3, 32'h0); wr(7, 32'h7F);
    end

    // R6: trigger disabled
    begin
      int pulses;
      pulses = 0;
      wr(8, 32'd2); wr(3, 32'h01);
      for (int k = 1; k <= 6 * S; k++) begin
        @(negedge clk);
        if (adc_trig) pulses++;
      end
      chk("R6 no trigger when bit5 clear", 32'(pulses), 32'h0);
      rd(5, v); chk("R6 status still sets", {31'b0, v[0]}, 32'h1);
      wr(3, 32'h0); wr(7, 32'h7F);
    end

    // R5: one-shot
    wr(1, 32'h1); wr(8, 32'd4); wr(3, 32'h21);
    for (int k = 1; k <= 12 * S; k++) begin
      @(negedge clk);
      chk("R5 single pulse", {31'b0, adc_trig}, {31'b0, k == 4 * S});
    end
    rd(3, v); chk("R5 enable self-cleared", v, 32'h20);
    wr(1, 32'h0); wr(3, 32'h0); wr(7, 32'h7F);

    // R10: config and mode frozen while enabled
    wr(8, 32'd4); wr(3, 32'h1);
    wr(0, 32'h1); rd(0, v); chk("R10 cfg ignored", v, 32'h0);
    wr(1, 32'h1); rd(1, v); chk("R10 modeA ignored", v, 32'h0);
    wr(2, 32'h5); rd(2, v); chk("R10 modeB ignored", v, 32'h0);
    wr(3, 32'h0); wr(7, 32'h7F);

    // R11: stop and restart from full interval
    wr(8, 32'd5); wr(3, 32'h1);
    idle(7);
    wr(3, 32'h0);
    idle(20);
    rd(5, v); chk("R11 stopped no status", v, 32'h0);
    wr(3, 32'h1);
    for (int k = 1; k <= 5 * S; k++) begin
      @(negedge clk);
      rd(5, v);
      chk("R11 restart full period", {31'b0, v[0]}, {31'b0, k >= 5 * S});
    end
    wr(3, 32'h0); wr(7, 32'h7F);

    // R7: RTC match sweep
    wr(0, 32'h1);
    for (int m = 1; m <= 4; m++) begin
      wr(10, 32'(m));
      wr(3, 32'h21);
      for (int k = 1; k <= (m + 1) * SEC; k++) begin
        @(negedge clk);
        rd(5, v);
        chk("R7 rtc match status", v, {28'b0, k >= m * SEC, 3'b0});
        chk("R7 no trigger", {31'b0, adc_trig}, 32'h0);
      end
      wr(3, 32'h0); wr(7, 32'h7F);
    end
    wr(0, 32'h0);

    // R8: masking of interrupt
    wr(1, 32'h1); wr(8, 32'd1); wr(3, 32'h1);
    idle(10);
    rd(5, v); chk("R8 raw set", v, 32'h1);
    wr(4, 32'h0);  chk("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(6, v); chk("R8 masked read zero", v, 32'h0);
    wr(4, 32'h1);  chk("R8 irq on", {31'b0, irq}, 32'h1);
    rd(6, v); chk("R8 masked read", v, 32'h1);
    wr(4, 32'h8);  chk("R8 other mask bit", {31'b0, irq}, 32'h0);
    wr(4, 32'h1);

    // R9: clear register
    wr(7, 32'h8); rd(5, v); chk("R9 other bit kept", v, 32'h1);
    wr(7, 32'h1); rd(5, v); chk("R9 bit cleared", v, 32'h0);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    wr(1, 32'h0); wr(4, 32'h0);

    // R12: unused configuration codes stay silent
    for (int c = 2; c < 8; c++) begin
      int pulses;
      pulses = 0;
      wr(0, 32'(c)); wr(8, 32'd1); wr(10, 32'd1); wr(3, 32'h21);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (adc_trig) pulses++;
      end
      chk("R12 no trigger", 32'(pulses), 32'h0);
      rd(5, v); chk("R12 no status", v, 32'h0);
      wr(3, 32'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule